// File: doc/BRIEF.md
# Single-to-Half Precision Narrowing Converter

This block takes a 32-bit single-precision floating-point bit pattern and produces the 16-bit half-precision bit pattern nearest to it. It rounds to nearest with ties to even, and it produces half subnormals correctly when a value falls below the normal half range. The conversion works only on bit patterns and uses no floating-point arithmetic. A mode pin chooses between two output formats. The standard half format has infinities and NaNs. The alternative half format has neither: it uses exponent code 31 for ordinary numbers and saturates anything too large.

A data path computes the result, and a small control unit tracks the valid flag. The control unit drives the data path through a struct of strobes. The parameter `REG_OUT` selects one of two variants. With `REG_OUT=1`, a result register gives a one-clock latency. With `REG_OUT=0`, the path is purely combinational and the valid flag passes straight through.

Top module: `f2h_narrow`

## Requirements
- R1: Output bit 15 always equals input bit 31. This includes zeros, NaNs, infinities and saturated results.
- R2: For a normal half result, the output exponent field (bits 14:10) is the single biased exponent minus 112, and bits 9:0 are the top ten bits of the rounded single mantissa. Examples: 1.0 (0x3F800000) gives 0x3C00, and 2^-14 (0x38800000) gives 0x0400.
- R3: Rounding is to nearest, with ties to even. Exactly half an output step rounds to the even code; anything above half rounds up.
- R4: Inputs with a biased exponent below 113 are rounded at a fixed step of 2^-24 into half subnormal codes. The largest such value can carry into the smallest normal code 0x0400.
- R5: Single-precision subnormal inputs, and inputs of magnitude at most 2^-25, give a signed zero (0x0000 or 0x8000).
- R6: In standard mode (modeAlt=0), a finite input whose rounded magnitude passes 65504 gives signed infinity (0x7C00 with the sign). For example, 65520 gives infinity, while 65504 stays 0x7BFF.
- R7: In standard mode, any NaN input gives 0x7E00 with the input sign in bit 15. An infinity input gives signed infinity.
- R8: In alternative mode (modeAlt=1), the input magnitude is first limited to the pattern 0x47FFE000 (131008). Every larger finite value, every infinity and every NaN gives code 0x7FFF with the sign. Values between 65504 and 131008 convert normally, using exponent code 31.
- R9: With REG_OUT=1, outValid rises one clock after inValid, and outBits then holds the result for the input seen on that cycle. When inValid is low, outBits keeps its value. A synchronous active-high reset clears outValid and outBits.
- R10: With REG_OUT=0, outValid equals inValid in the same cycle, and outBits is the result for the current input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input pattern is valid this cycle |
| modeAlt | input | 1 | 0 = standard half with infinity and NaN, 1 = alternative saturating half |
| inBits | input | 32 | Single-precision bit pattern |
| outValid | output | 1 | Result valid |
| outBits | output | 16 | Half-precision bit pattern |

## Verification
The bench builds two copies of the block side by side. `dut` uses REG_OUT=1 and the second copy uses REG_OUT=0, and both receive every vector, so the registered and combinational variants are checked against the same expected value.

The stimulus sweeps all 256 single exponents, each with a set of mantissa patterns aimed at the guard and sticky positions, and runs each sweep in both modes. This reaches the subnormal floor, every rounding carry, and the overflow and saturation boundaries. Random full-width patterns and directed values follow, including ties, 65504 and 65520, 2^-25, the clamp point, NaN and infinity.

// File: rtl/f2h_pkg.sv
`timescale 1ns/1ps
package f2h_pkg;
  localparam int SRC_W     = 32;
  localparam int SRC_EXP_W = 8;
  localparam int SRC_MAN_W = 23;
  localparam int DST_W     = 16;
  localparam int DST_EXP_W = 5;
  localparam int DST_MAN_W = 10;

  localparam int SRC_BIAS  = 2 ** (SRC_EXP_W - 1) - 1;
  localparam int DST_BIAS  = 2 ** (DST_EXP_W - 1) - 1;
  // lowest single exponent that still maps onto a normal half exponent
  localparam int EXP_FLOOR = SRC_BIAS - DST_BIAS + 1;
  localparam int DROP_BITS = SRC_MAN_W - DST_MAN_W;
  localparam int SIG_W     = SRC_MAN_W + 1;
  // beyond this shift every significand rounds to zero
  localparam int MAX_SHIFT = SIG_W + 1;
  localparam int MAX_GAP   = MAX_SHIFT - DROP_BITS;
  localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);
  localparam int Q_W       = DST_MAN_W + 2;
  localparam int CODE_W    = SRC_EXP_W + DST_MAN_W + 1;
  localparam int ALT_TOP_EXP = SRC_BIAS + (2 ** DST_EXP_W - 1) - DST_BIAS;

  localparam logic [SRC_W-2:0] ALT_CLAMP_MAG =
    {SRC_EXP_W'(ALT_TOP_EXP), {DST_MAN_W{1'b1}}, {DROP_BITS{1'b0}}};
  localparam logic [DST_W-2:0] INF_CODE  = {{DST_EXP_W{1'b1}}, {DST_MAN_W{1'b0}}};
  localparam logic [DST_W-2:0] QNAN_CODE = {{DST_EXP_W{1'b1}}, 1'b1, {(DST_MAN_W-1){1'b0}}};

  typedef enum logic {MODE_STD = 1'b0, MODE_ALT = 1'b1} f2h_mode_e;

  typedef struct packed {
    logic load;
    logic clear;
  } f2h_strobe_t;
endpackage

// File: rtl/f2h_rne.sv
`timescale 1ns/1ps
module f2h_rne
  import f2h_pkg::*;
(
  input  logic [SIG_W-1:0]   sig,
  input  logic [SHIFT_W-1:0] shiftAmt,
  output logic [Q_W-1:0]     rounded
);
  logic [SIG_W-1:0] kept;
  logic [SIG_W-1:0] dropMask;
  logic [SIG_W-1:0] halfPt;
  logic             guardBit;
  logic             stickyBit;
  logic             bumpUp;

  always_comb begin
    kept      = sig >> shiftAmt;
    dropMask  = ~({SIG_W{1'b1}} << shiftAmt);
    halfPt    = SIG_W'(1) << (shiftAmt - SHIFT_W'(1));
    guardBit  = |(sig & halfPt);
    stickyBit = |(sig & dropMask & ~halfPt);
    bumpUp    = guardBit & (stickyBit | kept[0]);
    rounded   = Q_W'(kept) + Q_W'(bumpUp);
  end
endmodule

// File: rtl/f2h_datapath.sv
`timescale 1ns/1ps
module f2h_datapath
  import f2h_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  f2h_strobe_t       strobe,
  input  logic              modeAlt,
  input  logic [SRC_W-1:0]  inBits,
  output logic [DST_W-1:0]  outBits
);
  logic                 sgn;
  logic [SRC_W-2:0]     rawMag;
  logic [SRC_W-2:0]     mag;
  logic [SRC_EXP_W-1:0] expF;
  logic [SRC_MAN_W-1:0] manF;
  logic                 isSpecial;
  logic                 belowFloor;
  logic [SRC_EXP_W-1:0] gap;
  logic [SIG_W-1:0]     sig;
  logic [SHIFT_W-1:0]   shiftAmt;
  logic [Q_W-1:0]       rounded;
  logic [CODE_W-1:0]    expOff;
  logic [CODE_W-1:0]    code;
  logic                 overflow;
  logic [DST_W-1:0]     result;
  f2h_mode_e            mode;

  always_comb begin
    mode   = f2h_mode_e'(modeAlt);
    sgn    = inBits[SRC_W-1];
    rawMag = inBits[SRC_W-2:0];
    mag    = (mode == MODE_ALT && rawMag > ALT_CLAMP_MAG) ? ALT_CLAMP_MAG : rawMag;
    expF   = mag[SRC_W-2 -: SRC_EXP_W];
    manF   = mag[SRC_MAN_W-1:0];
    isSpecial  = (mode == MODE_STD) && (expF == {SRC_EXP_W{1'b1}});
    belowFloor = expF < SRC_EXP_W'(EXP_FLOOR);
    gap        = SRC_EXP_W'(EXP_FLOOR) - expF;
    sig        = (expF == '0) ? '0 : {1'b1, manF};
    if (!belowFloor)
      shiftAmt = SHIFT_W'(DROP_BITS);
    else if (gap > SRC_EXP_W'(MAX_GAP))
      shiftAmt = SHIFT_W'(MAX_SHIFT);
    else
      shiftAmt = SHIFT_W'(DROP_BITS) + SHIFT_W'(gap);
  end

  f2h_rne u_rne (
    .sig      (sig),
    .shiftAmt (shiftAmt),
    .rounded  (rounded)
  );

  always_comb begin
    expOff   = CODE_W'(expF) - CODE_W'(EXP_FLOOR);
    code     = belowFloor ? CODE_W'(rounded) : (expOff << DST_MAN_W) + CODE_W'(rounded);
    overflow = (mode == MODE_STD) && (code >= CODE_W'(INF_CODE));
    if (isSpecial)
      result = {sgn, (manF != '0) ? QNAN_CODE : INF_CODE};
    else if (overflow)
      result = {sgn, INF_CODE};
    else
      result = {sgn, code[DST_W-2:0]};
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [DST_W-1:0] resQ;
      always_ff @(posedge clk) begin
        if (strobe.clear)     resQ <= '0;
        else if (strobe.load) resQ <= result;
      end
      assign outBits = resQ;
    end else begin : g_comb
      assign outBits = result;
    end
  endgenerate
endmodule

// File: rtl/f2h_ctrl.sv
`timescale 1ns/1ps
module f2h_ctrl
  import f2h_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output f2h_strobe_t strobe,
  output logic        outValid
);
  always_comb begin
    strobe.clear = rst;
    strobe.load  = inValid & ~rst;
  end

  generate
    if (REG_OUT) begin : g_reg
      logic validQ;
      always_ff @(posedge clk) begin
        if (strobe.clear) validQ <= 1'b0;
        else              validQ <= inValid;
      end
      assign outValid = validQ;
    end else begin : g_comb
      assign outValid = inValid;
    end
  endgenerate
endmodule

// File: rtl/f2h_narrow.sv
`timescale 1ns/1ps
module f2h_narrow
  import f2h_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        modeAlt,
  input  logic [31:0] inBits,
  output logic        outValid,
  output logic [15:0] outBits
);
  f2h_strobe_t strobe;

  f2h_ctrl #(.REG_OUT(REG_OUT)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  f2h_datapath #(.REG_OUT(REG_OUT)) u_dp (
    .clk     (clk),
    .strobe  (strobe),
    .modeAlt (modeAlt),
    .inBits  (inBits),
    .outBits (outBits)
  );
endmodule

// File: rtl/f2h_checker.sv
`timescale 1ns/1ps
module f2h_checker
  import f2h_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic        modeAlt,
  input logic [31:0] inBits,
  input logic        outValid,
  input logic [15:0] outBits
);
  logic [31:0] seenBits;
  logic        seenAlt;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (inValid) begin
          seenBits <= inBits;
          seenAlt  <= modeAlt;
        end
      end

      p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
        inValid |=> outValid);
      p_valid_drop_r9: assert property (@(posedge clk) disable iff (rst)
        !inValid |=> !outValid);
      p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !inValid |=> $stable(outBits));
    end else begin : g_comb
      assign seenBits = inBits;
      assign seenAlt  = modeAlt;

      p_comb_valid_r10: assert property (@(posedge clk) disable iff (rst)
        outValid == inValid);
    end
  endgenerate

  p_sign_r1: assert property (@(posedge clk) disable iff (rst)
    outValid |-> outBits[15] == seenBits[31]);

  p_nan_r7: assert property (@(posedge clk) disable iff (rst)
    (outValid && !seenAlt && seenBits[30:23] == 8'hFF && seenBits[22:0] != '0)
      |-> outBits[14:0] == QNAN_CODE);

  p_sat_r8: assert property (@(posedge clk) disable iff (rst)
    (outValid && seenAlt && seenBits[30:0] >= ALT_CLAMP_MAG)
      |-> outBits[14:0] == 15'h7FFF);

  p_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (outValid && seenBits[30:23] == '0) |-> outBits[14:0] == '0);

  p_top_code_r6: assert property (@(posedge clk) disable iff (rst)
    (outValid && !seenAlt && outBits[14:10] == 5'h1F)
      |-> (outBits[9:0] == 10'h000 || outBits[9:0] == 10'h200));
endmodule

bind f2h_narrow f2h_checker #(.REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .modeAlt  (modeAlt),
  .inBits   (inBits),
  .outValid (outValid),
  .outBits  (outBits)
);

// File: tb/tb_f2h_narrow.sv
`timescale 1ns/1ps
module tb_f2h_narrow;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        modeAlt = 1'b0;
  logic [31:0] inBits = '0;
  logic        outValidR, outValidC;
  logic [15:0] outBitsR, outBitsC;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic        pendValid = 1'b0;
  logic [15:0] pendExp = '0;
  string       pendTag = "R9";
  logic [15:0] holdExp = '0;
  logic [31:0] rng = 32'h1234_5678;

  always #2.5 clk = ~clk;

  f2h_narrow #(.REG_OUT(1'b1)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .modeAlt(modeAlt),
    .inBits(inBits), .outValid(outValidR), .outBits(outBitsR));

  f2h_narrow #(.REG_OUT(1'b0)) dutComb (
    .clk(clk), .rst(rst), .inValid(inValid), .modeAlt(modeAlt),
    .inBits(inBits), .outValid(outValidC), .outBits(outBitsC));

  // arithmetic reference: value = sig * 2^(e-150), quantised to the half grid
  function automatic logic [15:0] refConv(input logic [31:0] x, input logic alt);
    logic        s;
    logic [30:0] m31;
    int          e, sh;
    longint      sig, kept, rem, half, q, code;
    s   = x[31];
    m31 = x[30:0];
    if (alt && m31 > 31'h47FFE000) m31 = 31'h47FFE000;
    e = int'(m31[30:23]);
    if (!alt && e == 255) return (m31[22:0] != 0) ? {s, 15'h7E00} : {s, 15'h7C00};
    if (e == 0) return {s, 15'h0000};
    sig = 64'h80_0000 + longint'(m31[22:0]);
    sh  = (e >= 113) ? 13 : 13 + (113 - e);
    if (sh > 30) q = 0;
    else begin
      kept = sig >> sh;
      rem  = sig - (kept << sh);
      half = 64'd1 << (sh - 1);
      q = kept + (((rem > half) || (rem == half && kept[0])) ? 1 : 0);
    end
    code = (e >= 113) ? ((longint'(e - 113) << 10) + q) : q;
    if (!alt && code >= 31744) code = 31744;
    return {s, code[14:0]};
  endfunction

  function automatic string tagOf(input logic [31:0] x, input logic alt, input logic [15:0] e);
    if (alt && x[30:0] >= 31'h47FFE000) return "R8";
    if (!alt && x[30:23] == 8'hFF)     return "R7";
    if (x[30:23] == 0 || e[14:0] == 0) return "R5";
    if (!alt && e[14:0] == 15'h7C00)   return "R6";
    if (x[30:23] < 113)                return "R4";
    return "R2";
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] x, input logic alt, input logic vld,
                      input string tag, input logic [15:0] e);
    @(negedge clk);
    chk("R9", 16'(outValidR), 16'(pendValid));
    if (pendValid) holdExp = pendExp;
    chk(pendValid ? pendTag : "R9", outBitsR, holdExp);
    inValid = vld; modeAlt = alt; inBits = x;
    #1;
    chk("R10", 16'(outValidC), 16'(vld));
    if (vld) chk(tag, outBitsC, e);
    pendValid = vld; pendExp = e; pendTag = tag;
  endtask

  task automatic vec(input logic [31:0] x, input logic alt);
    logic [15:0] e;
    e = refConv(x, alt);
    step(x, alt, 1'b1, tagOf(x, alt, e), e);
  endtask

  function automatic logic [22:0] manPat(input int i, input logic [31:0] r);
    case (i)
      0: return 23'h000000;  1: return 23'h000001;  2: return 23'h001000;
      3: return 23'h000FFF;  4: return 23'h001001;  5: return 23'h002000;
      6: return 23'h003000;  7: return 23'h7FFFFF;  8: return 23'h7FE000;
      9: return 23'h7FF000; 10: return 23'h7FEFFF; 11: return 23'h400000;
      default: return r[22:0];
    endcase
  endfunction

  function automatic logic [31:0] nextRng(input logic [31:0] r);
    logic [31:0] t;
    t = r ^ (r << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  initial begin
    #(5.0 * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!finished) begin
      $display("%0d/%0d checks passed", nChecks + 1 - nFails, nChecks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state of the registered variant
    chk("R9", 16'(outValidR), 16'h0);
    chk("R9", outBitsR, 16'h0000);

    // directed values, standard mode
    step(32'h3F800000, 0, 1, "R2", 16'h3C00);
    step(32'hC0000000, 0, 1, "R1", 16'hC000);
    step(32'h38800000, 0, 1, "R2", 16'h0400);
    step(32'h3F801000, 0, 1, "R3", 16'h3C00);
    step(32'h3F803000, 0, 1, "R3", 16'h3C02);
    step(32'h3F801001, 0, 1, "R3", 16'h3C01);
    step(32'h477FE000, 0, 1, "R6", 16'h7BFF);
    step(32'h477FEFFF, 0, 1, "R6", 16'h7BFF);
    step(32'h477FF000, 0, 1, "R6", 16'h7C00);
    step(32'hC77FF000, 0, 1, "R6", 16'hFC00);
    step(32'h33800000, 0, 1, "R4", 16'h0001);
    step(32'h33000001, 0, 1, "R4", 16'h0001);
    step(32'h387FE000, 0, 1, "R4", 16'h0400);
    step(32'h33000000, 0, 1, "R5", 16'h0000);
    step(32'h80000001, 0, 1, "R5", 16'h8000);
    step(32'h7FC00000, 0, 1, "R7", 16'h7E00);
    step(32'hFF800001, 0, 1, "R7", 16'hFE00);
    step(32'h7F800000, 0, 1, "R7", 16'h7C00);
    step(32'hFF800000, 0, 1, "R7", 16'hFC00);
    // alternative mode
    step(32'h3F800000, 1, 1, "R8", 16'h3C00);
    step(32'h477FF000, 1, 1, "R8", 16'h7C00);
    step(32'h47FFC000, 1, 1, "R8", 16'h7FFE);
    step(32'h47FFE000, 1, 1, "R8", 16'h7FFF);
    step(32'h49742400, 1, 1, "R8", 16'h7FFF);
    step(32'h7F800000, 1, 1, "R8", 16'h7FFF);
    step(32'hFFC00000, 1, 1, "R8", 16'hFFFF);
    // idle cycle with different input: registered output must hold
    step(32'h3F800000, 0, 0, "R9", 16'h0000);
    step(32'h40000000, 0, 0, "R9", 16'h0000);

    // sweep all exponents with boundary mantissas, both modes
    for (int md = 0; md < 2; md++) begin
      for (int ex = 0; ex < 256; ex++) begin
        for (int i = 0; i < 24; i++) begin
          rng = nextRng(rng);
          vec({1'(ex + i), 8'(ex), manPat(i, rng)}, 1'(md));
        end
      end
    end
    // random full-width patterns
    for (int n = 0; n < 16000; n++) begin
      rng = nextRng(rng);
      vec(rng, 1'(n & 1));
    end

    // reset while a valid input is presented
    step(32'h3F800000, 0, 1, "R2", 16'h3C00);
    @(negedge clk);
    rst = 1'b1; inValid = 1'b1; inBits = 32'h40000000;
    @(negedge clk);
    chk("R9", 16'(outValidR), 16'h0);
    chk("R9", outBitsR, 16'h0000);
    rst = 1'b0; inValid = 1'b0;
    pendValid = 1'b0; holdExp = '0;
    step(32'h0, 0, 0, "R9", 16'h0);
    step(32'h0, 0, 0, "R9", 16'h0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule